// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

A single-channel transmitter that turns characters written by a host into asynchronous serial frames on one output line. Characters pass through a twelve-deep queue, a one-character staging register and the shift stage, so up to fourteen characters can be in the block at a time. Frame shape is set by configuration inputs: five to eight data bits, optional even or odd parity, and one or two stop bits. Bit timing comes from a baud tick pulse at sixteen times the bit rate.

The host drives a simple command interface. It enables and disables the channel, writes characters, and pulses an end-of-service strobe to release what it has written. A write sets a service gate that holds the queue until that strobe arrives. A level-style service request tells the host to refill. In one mode the request is raised as soon as the queue has drained into the staging register. In the other mode it is raised only once the staging register is empty and the last data bit of the final character has left the shift stage.

When the line runs out of data it idles at mark. Disabling the channel lets the character on the line finish, keeps everything else queued, and resumes sending on re-enable. A write to a full queue is discarded and sets a sticky overflow flag, which stays set until the host clears it.

Top module: `bufser_tx`

## Requirements
- R1: After reset the channel is disabled, `txd` is 1, and both `svc_req` and `ovf_flag` are 0.
- R2: Each frame is a 0 start bit, then 5 + `cfg_len_sel` data bits sent least-significant bit first (00 gives 5, 11 gives 8), then an optional parity bit, then one stop bit at 1 (two when `cfg_stop2` is 1). Each bit lasts 16 `baud_tick` pulses counted from the cycle the frame is loaded.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd` = 0 the total count of ones in data plus parity is even. With `cfg_par_odd` = 1 that count is odd.
- R4: The queue holds 12 characters, and with the staging register and the shift stage the block holds 14. A write while the queue holds 12 is dropped and sets `ovf_flag`. The flag stays 1 until `ovf_clr` is pulsed.
- R5: Pulsing `cmd_enable` while `req_en` is 1 and the queue is empty raises `svc_req` in the next cycle.
- R6: Any write sets the service gate. While the gate is set, no character leaves the queue and the line stays at mark. A `cmd_eos` pulse clears the gate.
- R7: When a character waits in the staging register and the channel is enabled, its start bit follows the previous frame's final stop bit with no idle cycle.
- R8: With `req_mode` = 0, `svc_req` is 1 exactly when the channel is enabled, `req_en` is 1 and the queue is empty.
- R9: With `req_mode` = 1, `svc_req` also requires the staging register to be empty and the shift stage to be in parity, stop or idle.
- R10: With nothing left to send, `txd` stays at 1 (mark).
- R11: A `cmd_disable` pulse lets the frame in flight finish, keeps queued and staged characters, and keeps the line at mark. `svc_req` is 0 while the channel is disabled. After `cmd_enable`, the kept characters are sent in order.
- R12: Frame configuration is sampled only when a character is loaded into the shift stage. Changing it in mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x bit rate |
| wr_valid | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| cmd_enable | input | 1 | Enable-channel pulse |
| cmd_disable | input | 1 | Disable-channel pulse (wins over enable) |
| cmd_eos | input | 1 | End-of-service pulse, releases written data |
| req_en | input | 1 | Service request enable |
| req_mode | input | 1 | 0: request on queue drained, 1: request after last data bit |
| cfg_len_sel | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| ovf_clr | input | 1 | Clears the overflow flag |
| txd | output | 1 | Serial output line |
| svc_req | output | 1 | Service request |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
The properties assume that `baud_tick`, `wr_valid`, the three command strobes and `ovf_clr` are single-cycle pulses sampled on the rising clock edge. They also assume that configuration may change at any time, because the design samples it only at frame load. The stimulus drives every input one nanosecond after a rising edge and never holds a strobe for more than one cycle. It produces the baud tick as a regular pulse every fourth cycle and changes configuration in mid-frame only to exercise the sampling rule. The reference model reads the same pins, so any mismatch points to the design rather than to stimulus timing.

// File: rtl/bufser_pkg.sv
package bufser_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } frame_cfg_t;

  function automatic logic [3:0] data_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  function automatic logic [CHAR_W-1:0] mask_data(input logic [CHAR_W-1:0] d,
                                                  input logic [1:0] sel);
    logic [CHAR_W:0] m;
    m = ({{CHAR_W{1'b0}}, 1'b1} << data_bits(sel)) - 1'b1;
    return d & m[CHAR_W-1:0];
  endfunction

  function automatic logic parity_of(input logic [CHAR_W-1:0] d, input frame_cfg_t c);
    return (^mask_data(d, c.len_sel)) ^ c.par_odd;
  endfunction
endpackage

// File: rtl/bufser_fifo.sv
module bufser_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= nxt(wr_ptr);
      end
      if (pop) rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bufser_shifter.sv
module bufser_shifter
  import bufser_pkg::*;
#(
  parameter int TPB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              take,
  input  logic [CHAR_W-1:0] ld_data,
  input  frame_cfg_t        ld_cfg,
  output logic              txd,
  output logic              idle,
  output logic              in_data,
  output logic              last_end
);
  localparam int CNTW = $clog2(TPB);

  phase_e            phase;
  logic [CNTW-1:0]   cnt;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] sh;
  frame_cfg_t        cfg_q;
  logic              par_q;
  logic              bit_end, data_done;

  assign bit_end   = tick && (cnt == CNTW'(TPB-1));
  assign data_done = ({1'b0, idx} == data_bits(cfg_q.len_sel) - 4'd1);
  assign idle      = (phase == PH_IDLE);
  assign in_data   = (phase == PH_START) || (phase == PH_DATA);
  assign last_end  = (phase == PH_STOP) && bit_end && (!cfg_q.stop2 || idx == 3'd1);

  always_comb begin
    case (phase)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = sh[0];
      PH_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      cfg_q <= '0;
      par_q <= 1'b0;
    end else if (take) begin
      phase <= PH_START;
      cnt   <= '0;
      idx   <= '0;
      sh    <= ld_data;
      cfg_q <= ld_cfg;
      par_q <= parity_of(ld_data, ld_cfg);
    end else if (phase != PH_IDLE && tick) begin
      if (!bit_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (phase)
          PH_START: begin
            phase <= PH_DATA;
            idx   <= '0;
          end
          PH_DATA: begin
            if (data_done) begin
              phase <= cfg_q.par_en ? PH_PAR : PH_STOP;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
              sh  <= sh >> 1;
            end
          end
          PH_PAR: begin
            phase <= PH_STOP;
            idx   <= '0;
          end
          default: begin
            if (last_end) phase <= PH_IDLE;
            else          idx   <= idx + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bufser_tx.sv
module bufser_tx
  import bufser_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int TPB   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_valid,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_eos,
  input  logic              req_en,
  input  logic              req_mode,
  input  logic [1:0]        cfg_len_sel,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              ovf_clr,
  output logic              txd,
  output logic              svc_req,
  output logic              ovf_flag
);
  localparam int CW = $clog2(DEPTH+1);

  logic              en_q, gate_q, hold_vld;
  logic [CHAR_W-1:0] hold_data, fifo_dout;
  logic [CW-1:0]     fifo_count;
  logic              fifo_empty, fifo_full, fifo_push, fifo_pop, wr_drop;
  logic              sh_take, sh_idle, sh_in_data, sh_last;
  frame_cfg_t        cfg_now;

  assign cfg_now   = '{len_sel: cfg_len_sel, par_en: cfg_par_en,
                       par_odd: cfg_par_odd, stop2: cfg_stop2};
  assign fifo_push = wr_valid && !fifo_full;
  assign wr_drop   = wr_valid && fifo_full;
  assign sh_take   = en_q && hold_vld && (sh_idle || sh_last);
  assign fifo_pop  = en_q && !gate_q && !fifo_empty && (!hold_vld || sh_take);
  assign svc_req   = en_q && req_en && fifo_empty &&
                     (!req_mode || (!hold_vld && !sh_in_data));

  bufser_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop), .din(wr_data),
    .dout(fifo_dout), .count(fifo_count), .empty(fifo_empty), .full(fifo_full)
  );

  bufser_shifter #(.TPB(TPB)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .take(sh_take),
    .ld_data(hold_data), .ld_cfg(cfg_now), .txd(txd), .idle(sh_idle),
    .in_data(sh_in_data), .last_end(sh_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      gate_q    <= 1'b0;
      ovf_flag  <= 1'b0;
      hold_vld  <= 1'b0;
      hold_data <= '0;
    end else begin
      if (cmd_disable)     en_q <= 1'b0;
      else if (cmd_enable) en_q <= 1'b1;

      if (cmd_eos)       gate_q <= 1'b0;
      else if (wr_valid) gate_q <= 1'b1;

      if (ovf_clr)      ovf_flag <= 1'b0;
      else if (wr_drop) ovf_flag <= 1'b1;

      if (fifo_pop) begin
        hold_data <= fifo_dout;
        hold_vld  <= 1'b1;
      end else if (sh_take) begin
        hold_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bufser_tx_chk.sv
module bufser_tx_chk #(
  parameter int DEPTH = 12,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          svc_req,
  input logic          ovf_flag,
  input logic          ovf_clr,
  input logic          req_en,
  input logic          req_mode,
  input logic          en_q,
  input logic          gate_q,
  input logic          fifo_pop,
  input logic          fifo_empty,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count,
  input logic          wr_drop,
  input logic          hold_vld,
  input logic          sh_take,
  input logic          sh_idle,
  input logic          sh_in_data,
  input logic          sh_last
);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_take |=> !txd);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));
  assert_drop_only_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |-> fifo_full);
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  assert_enable_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_q) && req_en && !req_mode && fifo_empty) |-> svc_req);
  assert_gate_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> !fifo_pop);
  assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_last && hold_vld && en_q) |-> sh_take);
  assert_req_queue_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> fifo_empty);
  assert_req_after_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && req_mode) |-> (!hold_vld && !sh_in_data));
  assert_idle_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sh_idle |-> txd);
  assert_disabled_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!sh_take && !fifo_pop && !svc_req));
endmodule

bind bufser_tx bufser_tx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .svc_req(svc_req), .ovf_flag(ovf_flag),
  .ovf_clr(ovf_clr), .req_en(req_en), .req_mode(req_mode), .en_q(en_q),
  .gate_q(gate_q), .fifo_pop(fifo_pop), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .fifo_count(fifo_count), .wr_drop(wr_drop),
  .hold_vld(hold_vld), .sh_take(sh_take), .sh_idle(sh_idle),
  .sh_in_data(sh_in_data), .sh_last(sh_last)
);

// File: tb/bufser_tx_tb.sv
`timescale 1ns/1ps
module bufser_tx_tb;
  logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic       wr_valid = 1'b0, cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_eos = 1'b0;
  logic [7:0] wr_data = '0;
  logic       req_en = 1'b0, req_mode = 1'b0, ovf_clr = 1'b0;
  logic [1:0] cfg_len_sel = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       txd, svc_req, ovf_flag;

  int checks = 0, errors = 0, cyc = 0;
  string cur_tag = "R1";

  bufser_tx u_dut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 baud_tick = (cyc % 4 == 3);
  end

  // reference model
  int  q[$];
  bit  fb[$];
  bit  m_en, m_gate, m_hv, m_ovf;
  int  m_hd, tcnt, m_tail, pre;
  bit  lastb, takeb, popb;

  task automatic build(input int d);
    int n, ones;
    fb.delete();
    fb.push_back(1'b0);
    n = 5 + cfg_len_sel;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      fb.push_back(bit'((d >> i) & 1));
      ones += (d >> i) & 1;
    end
    if (cfg_par_en) fb.push_back(bit'((ones % 2) ^ cfg_par_odd));
    fb.push_back(1'b1);
    if (cfg_stop2) fb.push_back(1'b1);
    m_tail = 1 + int'(cfg_par_en) + int'(cfg_stop2);
    tcnt = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); fb.delete();
      m_en = 0; m_gate = 0; m_hv = 0; m_ovf = 0; m_hd = 0; tcnt = 0; m_tail = 0;
    end else begin
      pre   = q.size();
      lastb = (fb.size() == 1) && baud_tick && (tcnt == 15);
      takeb = m_en && m_hv && (fb.size() == 0 || lastb);
      popb  = m_en && !m_gate && pre > 0 && (!m_hv || takeb);
      if (fb.size() > 0 && baud_tick) begin
        if (tcnt == 15) begin void'(fb.pop_front()); tcnt = 0; end
        else tcnt++;
      end
      if (takeb) build(m_hd);
      if (popb) begin m_hd = q.pop_front(); m_hv = 1; end
      else if (takeb) m_hv = 0;
      if (wr_valid) begin
        if (pre < 12) q.push_back(int'(wr_data));
      end
      if (ovf_clr) m_ovf = 0;
      else if (wr_valid && pre >= 12) m_ovf = 1;
      if (cmd_eos) m_gate = 0; else if (wr_valid) m_gate = 1;
      if (cmd_disable) m_en = 0; else if (cmd_enable) m_en = 1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_tag, txd, fb.size() ? fb[0] : 1'b1, "txd");
      chk(cur_tag, svc_req, m_en && req_en && q.size() == 0 &&
          (!req_mode || (!m_hv && fb.size() <= m_tail)), "svc_req");
      chk(cur_tag, ovf_flag, m_ovf, "ovf_flag");
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic wr(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d; step(1); wr_valid = 1'b0;
  endtask
  task automatic pulse_en();  cmd_enable = 1'b1;  step(1); cmd_enable = 1'b0;  endtask
  task automatic pulse_dis(); cmd_disable = 1'b1; step(1); cmd_disable = 1'b0; endtask
  task automatic pulse_eos(); cmd_eos = 1'b1;     step(1); cmd_eos = 1'b0;     endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    cur_tag = "R1";
    chk("R1", txd, 1'b1, "txd after reset");
    chk("R1", svc_req, 1'b0, "svc_req after reset");
    chk("R1", ovf_flag, 1'b0, "ovf_flag after reset");

    cur_tag = "R5";
    req_en = 1'b1;
    pulse_en();
    chk("R5", svc_req, 1'b1, "request right after enable");

    cur_tag = "R6";
    wr(8'hA5); wr(8'h3C); wr(8'hF0);
    step(300);
    chk("R6", txd, 1'b1, "line held while gated");
    pulse_eos();

    cur_tag = "R7";
    step(700);
    cur_tag = "R8";
    step(1400);
    cur_tag = "R10";
    step(300);
    chk("R10", txd, 1'b1, "mark after underrun");

    cur_tag = "R3";
    cfg_len_sel = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b1;
    wr(8'h1B); wr(8'h07); pulse_eos();
    step(1800);
    cfg_len_sel = 2'd2; cfg_par_odd = 1'b1; cfg_stop2 = 1'b0;
    wr(8'h55); wr(8'h6E); pulse_eos();
    cur_tag = "R2";
    step(1500);

    cur_tag = "R9";
    req_mode = 1'b1; cfg_len_sel = 2'd3; cfg_par_en = 1'b1;
    wr(8'hC3); wr(8'h81); pulse_eos();
    step(1800);
    chk("R9", svc_req, 1'b1, "request once all sent");
    req_mode = 1'b0;

    cur_tag = "R12";
    cfg_par_en = 1'b0;
    wr(8'h9A); wr(8'h42); wr(8'h17); pulse_eos();
    step(100);
    cfg_len_sel = 2'd1; cfg_par_en = 1'b1; cfg_stop2 = 1'b1;
    step(2500);

    cur_tag = "R11";
    cfg_len_sel = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44); wr(8'h55); pulse_eos();
    step(100);
    pulse_dis();
    step(2500);
    chk("R11", txd, 1'b1, "mark while disabled");
    chk("R11", svc_req, 1'b0, "no request while disabled");
    pulse_en();
    step(3200);

    cur_tag = "R4";
    for (int i = 0; i < 12; i++) wr(8'(8'h60 + i));
    chk("R4", ovf_flag, 1'b0, "no overflow at 12 queued");
    pulse_eos();
    step(6);
    wr(8'hE1); wr(8'hE2);
    chk("R4", ovf_flag, 1'b0, "14 held without overflow");
    wr(8'hE3);
    chk("R4", ovf_flag, 1'b1, "overflow on 15th");
    step(50);
    chk("R4", ovf_flag, 1'b1, "overflow sticky");
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk("R4", ovf_flag, 1'b0, "overflow cleared");
    pulse_eos();
    step(10000);
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end
endmodule